// File: doc/BRIEF.md
# DVMA Page Table Translator

This block turns a 32-bit device virtual address into a physical address. It makes one single-level lookup in a page table that sits in memory. A device places a request carrying the address and a read/write indication. The block computes where the matching table entry lives, from a table base value and a window-start value that a nearby register block supplies. It then issues one memory read for that entry. From the entry it builds the physical address and reports the entry's permission bits beside it.

The block handles one translation at a time. While a lookup is in progress, the request side is held off. A finished response stays on the outputs until the consumer takes it. An entry that is not valid, or a write that targets a read-only entry, raises a fault flag in place of a usable address. When translation is switched off, the block hands the device address straight back and does not touch memory.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 while `rsp_valid` and `mem_rd_req` are both 0. `req_ready` is 1 only while no translation is in progress, so only one request is taken at a time.
- R2: When translation is enabled, the entry read address is `(tbl_base << 4) + (((req_addr & ~win_start) >> 10)` with bits [1:0] forced to 0 `)`, computed modulo 2^32.
- R3: When translation is enabled, exactly one memory read is issued. It is first seen in the cycle after the request is accepted. `mem_rd_req` and `mem_rd_addr` stay unchanged until `mem_rd_ack` is seen.
- R4: For a usable entry, `rsp_paddr[30:12]` equals entry bits [26:8] and `rsp_paddr[31]` is 0. Entry bits [31:27] and [7:0] never reach the address. `rsp_valid` rises in the cycle after the acknowledge.
- R5: For a usable entry, `rsp_paddr[11:0]` equals `req_addr[11:0]`, because pages are 4 KB.
- R6: An entry with bit 1 (valid) at 0 gives `rsp_fault` = 1 and `rsp_paddr` = 0, for both reads and writes.
- R7: A write request (`req_write` = 1) to an entry with bit 2 (writeable) at 0 gives `rsp_fault` = 1 and `rsp_paddr` = 0. A read request to the same entry does not fault.
- R8: `rsp_cache` reports entry bit 7 and `rsp_writable` reports entry bit 2. Entry bit 0 (write-as-zero) has no effect on any response output.
- R9: When `xl_en` is 0 at acceptance, no memory read is issued. In the next cycle the response carries `rsp_paddr` = `req_addr`, `rsp_fault` = 0, `rsp_cache` = 0 and `rsp_writable` = 1.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, every response output holds its value. The cycle after `rsp_ready` is seen, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_en | input | 1 | Translation enable, sampled when a request is accepted |
| tbl_base | input | 32 | Page-table base value; shifted left by 4 to form a byte address |
| win_start | input | 32 | Start of the translation window; these bits are stripped from the address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write access |
| mem_rd_req | output | 1 | Entry read request |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rd_ack | input | 1 | Entry read completes; data valid this cycle |
| mem_rd_data | input | 32 | Entry read data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, or 0 on fault |
| rsp_fault | output | 1 | Translation fault |
| rsp_cache | output | 1 | Entry cacheable bit |
| rsp_writable | output | 1 | Entry writeable bit |

## Verification
The bench sweeps all eight power-of-two window sizes, from 16 MB up to 2 GB. Each size uses several device addresses whose upper bits lie partly outside the window, and this exposes any fault in how window bits are stripped from the entry index. At every size, four kinds of entry are tried with both reads and writes: writeable, read-only with the cache bit set, invalid, and writeable with the write-as-zero bit set. Together they separate a correct address from the valid-bit fault and from the write-permission fault. Every entry also carries junk in the bits outside the page-number field, which shows whether those bits leak into the address. Read latency and response back-pressure vary from call to call, and a run with translation disabled checks the pass-through path and that no memory access is made.

// File: rtl/dvma_xlate_pkg.sv
// Package: shared state encoding and entry bit positions for the translator.
// Assumes the entry layout: valid at bit 1, writeable at bit 2, cacheable at bit 7.
package dvma_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } xl_state_e;

    localparam int unsigned PTE_VALID_BIT = 1;
    localparam int unsigned PTE_WRITE_BIT = 2;
    localparam int unsigned PTE_CACHE_BIT = 7;

endpackage

// File: rtl/dvma_pte_addr.sv
// Module: dvma_pte_addr
// Computes the byte address of a page-table entry from the device address,
// the table base and the window start. Purely combinational.
// Assumes entries are 4 bytes wide and pages are 2**PAGE_SHIFT bytes.
module dvma_pte_addr #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned BASE_SHIFT = 4
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] win,
    output logic [ADDR_W-1:0] pte_addr
);
    localparam int unsigned IDX_SHIFT = PAGE_SHIFT - 2;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(3));

    logic [ADDR_W-1:0] stripped;
    logic [ADDR_W-1:0] idx_bytes;

    // Strip window bits, scale the page index to a word-aligned byte offset, add base.
    always_comb begin
        stripped  = vaddr & ~win;
        idx_bytes = (stripped >> IDX_SHIFT) & ALIGN_MASK;
        pte_addr  = (base << BASE_SHIFT) + idx_bytes;
    end
endmodule

// File: rtl/dvma_pte_decode.sv
// Module: dvma_pte_decode
// Turns a fetched entry and the request's page offset into a physical address,
// fault flag and permission bits. Purely combinational.
// Assumes the page number sits in entry bits [PPN_HI:PPN_LO] and that it
// moves left by BASE_SHIFT to land on physical bit PAGE_SHIFT.
module dvma_pte_decode
    import dvma_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned BASE_SHIFT = 4,
    parameter int unsigned PPN_LO     = 8,
    parameter int unsigned PPN_HI     = 26
) (
    input  logic [ADDR_W-1:0]     pte,
    input  logic [PAGE_SHIFT-1:0] offset,
    input  logic                  is_write,
    output logic [ADDR_W-1:0]     paddr,
    output logic                  fault,
    output logic                  cache,
    output logic                  writable
);
    localparam logic [ADDR_W-1:0] PPN_MASK =
        ((ADDR_W'(1) << (PPN_HI + 1)) - ADDR_W'(1)) & ~((ADDR_W'(1) << PPN_LO) - ADDR_W'(1));

    logic [ADDR_W-1:0] frame;

    // Decode permissions, fault condition and the translated address.
    always_comb begin
        writable = pte[PTE_WRITE_BIT];
        cache    = pte[PTE_CACHE_BIT];
        fault    = !pte[PTE_VALID_BIT] || (is_write && !pte[PTE_WRITE_BIT]);
        frame    = (pte & PPN_MASK) << BASE_SHIFT;
        paddr    = fault ? '0 : (frame | {{(ADDR_W-PAGE_SHIFT){1'b0}}, offset});
    end
endmodule

// File: rtl/dvma_xlate_fsm.sv
// Module: dvma_xlate_fsm
// Sequences one translation at a time: accept, fetch the entry, hold the response.
// Assumes the caller provides the entry address and the decoded response
// combinationally; enable is sampled only at acceptance.
module dvma_xlate_fsm
    import dvma_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xl_en,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     pte_addr,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_ack,
    output logic [PAGE_SHIFT-1:0] off_q,
    output logic                  wr_q,
    input  logic [ADDR_W-1:0]     dec_paddr,
    input  logic                  dec_fault,
    input  logic                  dec_cache,
    input  logic                  dec_writable,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [ADDR_W-1:0]     rsp_paddr,
    output logic                  rsp_fault,
    output logic                  rsp_cache,
    output logic                  rsp_writable
);
    xl_state_e         state;
    logic [ADDR_W-1:0] ent_q;

    // State register, captured request fields and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            ent_q        <= '0;
            off_q        <= '0;
            wr_q         <= 1'b0;
            rsp_paddr    <= '0;
            rsp_fault    <= 1'b0;
            rsp_cache    <= 1'b0;
            rsp_writable <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        off_q <= req_addr[PAGE_SHIFT-1:0];
                        wr_q  <= req_write;
                        if (xl_en) begin
                            ent_q <= pte_addr;
                            state <= ST_FETCH;
                        end else begin
                            rsp_paddr    <= req_addr;
                            rsp_fault    <= 1'b0;
                            rsp_cache    <= 1'b0;
                            rsp_writable <= 1'b1;
                            state        <= ST_DONE;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rd_ack) begin
                        rsp_paddr    <= dec_paddr;
                        rsp_fault    <= dec_fault;
                        rsp_cache    <= dec_cache;
                        rsp_writable <= dec_writable;
                        state        <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs follow the state directly.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        mem_rd_req  = (state == ST_FETCH);
        mem_rd_addr = ent_q;
        rsp_valid   = (state == ST_DONE);
    end
endmodule

// File: rtl/dvma_xlate.sv
// Module: dvma_xlate (top)
// Single-level page-table translator for device addresses: one entry read
// per request, fault on invalid or write-protected entries, pass-through
// when disabled. Assumes tbl_base and win_start are steady while a request is accepted.
module dvma_xlate #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned BASE_SHIFT = 4,
    parameter int unsigned PPN_LO     = 8,
    parameter int unsigned PPN_HI     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xl_en,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] win_start,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_cache,
    output logic              rsp_writable
);
    logic [ADDR_W-1:0]     pte_addr;
    logic [PAGE_SHIFT-1:0] off_q;
    logic                  wr_q;
    logic [ADDR_W-1:0]     dec_paddr;
    logic                  dec_fault;
    logic                  dec_cache;
    logic                  dec_writable;

    dvma_pte_addr #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .BASE_SHIFT(BASE_SHIFT)
    ) u_addr (
        .vaddr(req_addr), .base(tbl_base), .win(win_start), .pte_addr(pte_addr)
    );

    dvma_pte_decode #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .BASE_SHIFT(BASE_SHIFT),
        .PPN_LO(PPN_LO), .PPN_HI(PPN_HI)
    ) u_dec (
        .pte(mem_rd_data), .offset(off_q), .is_write(wr_q),
        .paddr(dec_paddr), .fault(dec_fault), .cache(dec_cache), .writable(dec_writable)
    );

    dvma_xlate_fsm #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .pte_addr(pte_addr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .off_q(off_q), .wr_q(wr_q),
        .dec_paddr(dec_paddr), .dec_fault(dec_fault), .dec_cache(dec_cache),
        .dec_writable(dec_writable),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cache(rsp_cache), .rsp_writable(rsp_writable)
    );
endmodule

// File: rtl/dvma_xlate_chk.sv
// Module: dvma_xlate_chk
// Protocol and result properties for dvma_xlate, attached by bind.
// Assumes the same parameters as the instance it watches.
module dvma_xlate_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xl_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ack,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_fault,
    input logic              rsp_cache,
    input logic              rsp_writable
);
    logic [PAGE_SHIFT-1:0] seen_off;

    // Remember the page offset of the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_off <= '0;
        else if (req_valid && req_ready) seen_off <= req_addr[PAGE_SHIFT-1:0];
    end

    a_r1_busy_blocks_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || rsp_valid) |-> !req_ready);

    a_r3_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r3_no_read_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_rd_req);

    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_SHIFT-1:0] == seen_off));

    a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    a_r9_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=>
        (rsp_valid && !mem_rd_req && !rsp_fault && rsp_paddr == $past(req_addr)));

    a_r10_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
         && $stable(rsp_cache) && $stable(rsp_writable)));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));
endmodule

bind dvma_xlate dvma_xlate_chk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
    .clk(clk), .rst_n(rst_n), .xl_en(xl_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cache(rsp_cache), .rsp_writable(rsp_writable)
);

// File: tb/test_dvma_xlate.sv
`timescale 1ns/1ps
module test_dvma_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_en = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [31:0] win_start = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_cache;
    logic        rsp_writable;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dvma_xlate i_dvma_xlate (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .tbl_base(tbl_base), .win_start(win_start),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cache(rsp_cache),
        .rsp_writable(rsp_writable)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full translation with bench-computed expectations.
    task automatic xlate(input logic [31:0] va, input bit wr, input logic [31:0] pte,
                         input bit en, input int delay, input int hold);
        logic [31:0] exp_ent, exp_pa, pa0;
        bit exp_f, exp_c, exp_w, f0, c0, w0;
        string tg;
        exp_ent = (tbl_base << 4) + (((va & ~win_start) >> 10) & 32'hFFFF_FFFC);
        if (!en) begin
            exp_f = 0; exp_c = 0; exp_w = 1; exp_pa = va; tg = "R9";
        end else begin
            exp_f = !pte[1] || (wr && !pte[2]);
            exp_c = pte[7]; exp_w = pte[2];
            exp_pa = exp_f ? 32'h0 : (((pte & 32'h07FF_FF00) << 4) + (va & 32'hFFF));
            tg = !pte[1] ? "R6" : ((wr && !pte[2]) ? "R7" : "R4");
        end
        @(negedge clk);
        xl_en = en; req_addr = va; req_write = wr; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R1 ready when idle", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (en) begin
            chk(mem_rd_req == 1'b1, "R3 read issued", {31'b0, mem_rd_req}, 32'd1);
            chk(mem_rd_addr == exp_ent, "R2 entry address", mem_rd_addr, exp_ent);
            chk(req_ready == 1'b0, "R1 busy blocks requests", {31'b0, req_ready}, 32'd0);
            for (int d = 0; d < delay; d++) begin
                @(negedge clk);
                chk(mem_rd_req && mem_rd_addr == exp_ent, "R3 read held", mem_rd_addr, exp_ent);
            end
            mem_rd_ack = 1'b1; mem_rd_data = pte;
            @(negedge clk);
            mem_rd_ack = 1'b0; mem_rd_data = 32'hDEAD_BEEF;
        end else begin
            chk(mem_rd_req == 1'b0, "R9 no memory read", {31'b0, mem_rd_req}, 32'd0);
        end
        chk(rsp_valid == 1'b1, "R4 response valid", {31'b0, rsp_valid}, 32'd1);
        chk(rsp_paddr == exp_pa, {tg, " physical address"}, rsp_paddr, exp_pa);
        chk(rsp_fault == exp_f, {tg, " fault flag"}, {31'b0, rsp_fault}, {31'b0, exp_f});
        chk(rsp_cache == exp_c, "R8 cache bit", {31'b0, rsp_cache}, {31'b0, exp_c});
        chk(rsp_writable == exp_w, "R8 writeable bit", {31'b0, rsp_writable}, {31'b0, exp_w});
        if (!exp_f) chk(rsp_paddr[11:0] == va[11:0], "R5 page offset", {20'b0, rsp_paddr[11:0]}, {20'b0, va[11:0]});
        pa0 = rsp_paddr; f0 = rsp_fault; c0 = rsp_cache; w0 = rsp_writable;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == pa0 && rsp_fault == f0 && rsp_cache == c0
                && rsp_writable == w0, "R10 response held", rsp_paddr, pa0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R10 released after accept",
            {30'b0, rsp_valid, req_ready}, 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pte_a, pa_a, pa_b;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_req == 1'b0, "R1 reset state",
            {29'b0, req_ready, rsp_valid, mem_rd_req}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_req == 1'b0, "R1 idle after reset",
            {29'b0, req_ready, rsp_valid, mem_rd_req}, 32'd4);

        // Sweep all window sizes, several addresses, entry kinds, read and write.
        for (int k = 0; k < 8; k++) begin
            win_start = 32'hFFFF_FFFF << (24 + k);
            tbl_base  = 32'h0001_2300 + 32'h40 * k;
            for (int i = 0; i < 4; i++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [31:0] va, pte, flags;
                        va = 32'h9E37_79B9 * (i + 1 + k * 4);
                        case (p)
                            0: flags = 32'h06;
                            1: flags = 32'h82;
                            2: flags = 32'h04;
                            default: flags = 32'h87;
                        endcase
                        pte = 32'hF800_0078 | ((32'h2545_F491 * (i + 3 * p + 1)) & 32'h07FF_FF00) | flags;
                        xlate(va, w[0], pte, 1'b1, (i + p) % 3, (k == 0) ? 2 : w);
                    end
                end
            end
        end

        // R8: bit 0 of the entry changes nothing.
        win_start = 32'hFF00_0000; tbl_base = 32'h0000_0400;
        pte_a = 32'h0123_4586;
        xlate(32'hFF12_3ABC, 1'b1, pte_a, 1'b1, 0, 0);
        pa_a = 32'h1234_5ABC;
        xlate(32'hFF12_3ABC, 1'b1, pte_a | 32'h1, 1'b1, 1, 0);
        pa_b = ((pte_a & 32'h07FF_FF00) << 4) + 32'hABC;
        chk(pa_a == pa_b, "R8 write-as-zero bit has no effect", pa_b, pa_a);

        // R9: disabled translation passes addresses through, back to back.
        xlate(32'hFEDC_BA98, 1'b0, 32'h0, 1'b0, 0, 1);
        xlate(32'h0000_0FFF, 1'b1, 32'h0, 1'b0, 0, 0);
        xlate(32'h8000_0000, 1'b0, 32'h0, 1'b0, 0, 0);
        // Re-enable after bypass to check the state returns cleanly.
        xlate(32'hFF00_0000, 1'b0, 32'h0000_0106, 1'b1, 2, 1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule